// File: doc/BRIEF.md
# Flash Power-Mode and Reset Controller

This block is the control front-end of a flash memory device. It registers one power mode each clock from three inputs: an active-low power-down pin, two active-low chip enables, and activity on the address inputs. Pulling the power-down pin low puts the device into deep power-down. On entry the block sends a one-cycle abort to the write state machine. For the whole time the pin stays low it holds a clear request on the three status registers.

When the pin returns high, a recovery timer keeps the data output enable off for a fixed time. That time is given in nanoseconds and turned into clock cycles from a clock-period parameter. If either chip enable is high, the device sits in standby. If it is selected but the address has not changed for a set number of cycles, it drops into automatic power saving. The first address change brings it back to active.

The block also maps the external address to an internal address. With the width pin high, the device is word-wide and the lowest external address bit is ignored. With the width pin low, every external bit is used and bit 0 selects the byte lane.

Top module: `flashctl_power_front`

## Requirements
- R1: The mode output is registered and uses this encoding: 2'b00 active, 2'b01 power saving, 2'b10 standby, 2'b11 deep power-down. It is chosen by priority in that order: deep power-down first, then standby, then power saving, then active.
- R2: When the power-down pin is sampled low at a rising edge, the mode after that edge is deep power-down.
- R3: The abort output is high for exactly one cycle, starting at the edge where deep power-down is entered from any other mode. It stays low while deep power-down continues.
- R4: The register-clear output is high exactly while the mode is deep power-down.
- R5: After the power-down pin is sampled high again, and also after the synchronous reset, output enable stays low for REC = ceil(RECOVERY_NS*1000/CLK_PERIOD_PS) rising edges with the pin high. With the defaults this is 50 edges at 10 ns.
- R6: When the power-down pin is high and either chip enable is high at an edge, the mode after that edge is standby.
- R7: Power saving is entered at the (IDLE_CYC+1)-th consecutive edge at which the device is selected (pin high, both chip enables low) and the address equals its value at the previous edge.
- R8: An address change while the device is selected returns the mode to active at that same edge.
- R9: Output enable is high only when the mode is active or power saving and the recovery time has elapsed.
- R10: When the width pin is high, the internal address is the external address shifted right by one, with the top bit zero, and the lane output is 0.
- R11: When the width pin is low, the internal address equals the external address, and the lane output equals external address bit 0.
- R12: While reset is held, the mode is standby and output enable, abort and register-clear are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n_i | input | 1 | Power-down pin, low enters deep power-down |
| ce_n_i | input | 2 | Two active-low chip enables |
| wide_i | input | 1 | Width select, high for word-wide mode |
| addr_i | input | ADDR_W | External address |
| mode_o | output | 2 | Encoded power mode |
| out_en_o | output | 1 | Data output enable |
| wsm_abort_o | output | 1 | One-cycle abort to the write state machine |
| reg_clr_o | output | 1 | Clear request to the three status registers |
| int_addr_o | output | ADDR_W | Mapped internal address |
| lane_o | output | 1 | Byte lane within a word |

## Verification
A mode register that has fallen out of step with its inputs shows up on mode_o at the next edge. It also shows on out_en_o, which would turn on inside standby or deep power-down. A recovery counter that loads or counts wrongly moves the first cycle of output enable away from edge REC, and the bench checks this on every edge of the window. An idle counter with the wrong limit or reset moves the power-saving entry off edge IDLE_CYC+1, and this is visible within a few cycles. An abort that does not clear shows as a second high cycle straight away.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'b00,
        PM_SAVE    = 2'b01,
        PM_STANDBY = 2'b10,
        PM_DEEP    = 2'b11
    } pm_mode_e;

    typedef struct packed {
        logic deep;
        logic standby;
        logic quiet;
    } pm_req_t;

    function automatic int rec_cycles(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic logic drives_out(input pm_mode_e m);
        return (m == PM_ACTIVE) || (m == PM_SAVE);
    endfunction

endpackage

// File: rtl/pf_addr_map.sv
`timescale 1ns/1ps
module pf_addr_map #(
    parameter int ADDR_W = 21
) (
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] int_addr_o,
    output logic              lane_o
);
    always_comb begin
        if (wide_i) begin
            int_addr_o = {1'b0, addr_i[ADDR_W-1:1]};
            lane_o     = 1'b0;
        end else begin
            int_addr_o = addr_i;
            lane_o     = addr_i[0];
        end
    end
endmodule

// File: rtl/pf_idle_mon.sv
`timescale 1ns/1ps
module pf_idle_mon #(
    parameter int ADDR_W   = 21,
    parameter int IDLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              moved_o,
    output logic              quiet_o
);
    localparam int IDLE_W = $clog2(IDLE_CYC + 1);
    localparam logic [IDLE_W-1:0] IDLE_TOP = IDLE_W'(IDLE_CYC);

    logic [ADDR_W-1:0] addr_q;
    logic [IDLE_W-1:0] cnt_q;

    assign moved_o = (addr_i != addr_q);
    assign quiet_o = (cnt_q == IDLE_TOP) && !moved_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            addr_q <= addr_i;
            if (!sel_i || moved_o)
                cnt_q <= '0;
            else if (cnt_q != IDLE_TOP)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= IDLE_TOP);  // R7
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !sel_i |=> cnt_q == '0);  // R7
endmodule

// File: rtl/pf_recovery.sv
`timescale 1ns/1ps
module pf_recovery #(
    parameter int REC_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_low_i,
    output logic settled_o
);
    localparam int REC_W = $clog2(REC_CYC + 1);
    localparam logic [REC_W-1:0] REC_TOP = REC_W'(REC_CYC);

    logic [REC_W-1:0] left_q;

    assign settled_o = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst || pin_low_i)
            left_q <= REC_TOP;
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    AST_REC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        pin_low_i |=> !settled_o);  // R5
    AST_REC_MONO: assert property (@(posedge clk) disable iff (rst)
        (settled_o && !pin_low_i) |=> settled_o);  // R5
endmodule

// File: rtl/pf_mode_fsm.sv
`timescale 1ns/1ps
module pf_mode_fsm
    import pf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pm_req_t  req_i,
    output pm_mode_e mode_o,
    output logic     abort_o
);
    pm_mode_e mode_q, mode_d;
    logic     abort_q;

    always_comb begin
        if (req_i.deep)         mode_d = PM_DEEP;
        else if (req_i.standby) mode_d = PM_STANDBY;
        else if (req_i.quiet)   mode_d = PM_SAVE;
        else                    mode_d = PM_ACTIVE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= PM_STANDBY;
            abort_q <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            abort_q <= req_i.deep && (mode_q != PM_DEEP);
        end
    end

    assign mode_o  = mode_q;
    assign abort_o = abort_q;

    AST_DEEP_WINS: assert property (@(posedge clk) disable iff (rst)
        req_i.deep |=> mode_q == PM_DEEP);  // R2
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        abort_q |=> !abort_q);  // R3
    AST_ABORT_IN_DEEP: assert property (@(posedge clk) disable iff (rst)
        abort_q |-> mode_q == PM_DEEP);  // R3
endmodule

// File: rtl/flashctl_power_front.sv
`timescale 1ns/1ps
module flashctl_power_front
    import pf_pkg::*;
#(
    parameter int ADDR_W        = 21,
    parameter int IDLE_CYC      = 16,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int RECOVERY_NS   = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n_i,
    input  logic [1:0]        ce_n_i,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [1:0]        mode_o,
    output logic              out_en_o,
    output logic              wsm_abort_o,
    output logic              reg_clr_o,
    output logic [ADDR_W-1:0] int_addr_o,
    output logic              lane_o
);
    localparam int REC_CYC = rec_cycles(RECOVERY_NS, CLK_PERIOD_PS);

    logic     selected;
    logic     addr_moved;
    logic     quiet;
    logic     settled;
    pm_req_t  req;
    pm_mode_e mode;

    assign selected = pd_n_i && (ce_n_i == 2'b00);

    pf_idle_mon #(.ADDR_W(ADDR_W), .IDLE_CYC(IDLE_CYC)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (selected),
        .addr_i  (addr_i),
        .moved_o (addr_moved),
        .quiet_o (quiet)
    );

    pf_recovery #(.REC_CYC(REC_CYC)) u_rec (
        .clk       (clk),
        .rst       (rst),
        .pin_low_i (!pd_n_i),
        .settled_o (settled)
    );

    always_comb begin
        req.deep    = !pd_n_i;
        req.standby = pd_n_i && (ce_n_i != 2'b00);
        req.quiet   = quiet;
    end

    pf_mode_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .mode_o  (mode),
        .abort_o (wsm_abort_o)
    );

    pf_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .wide_i     (wide_i),
        .addr_i     (addr_i),
        .int_addr_o (int_addr_o),
        .lane_o     (lane_o)
    );

    assign mode_o    = mode;
    assign reg_clr_o = (mode == PM_DEEP);
    assign out_en_o  = drives_out(mode) && settled;

    AST_STBY_ON_CE: assert property (@(posedge clk) disable iff (rst)
        (pd_n_i && ce_n_i != 2'b00) |=> mode_o == 2'b10);  // R6
    AST_CLR_IN_DEEP: assert property (@(posedge clk) disable iff (rst)
        !pd_n_i |=> reg_clr_o);  // R4
    AST_OE_OFF_DEEP: assert property (@(posedge clk) disable iff (rst)
        !pd_n_i |=> !out_en_o);  // R9
    AST_OE_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_n_i) |=> !out_en_o);  // R5
    AST_SAVE_EXIT: assert property (@(posedge clk) disable iff (rst)
        addr_moved |=> mode_o != 2'b01);  // R8
endmodule

// File: tb/sim_flashctl_power_front.sv
`timescale 1ns/1ps
module sim_flashctl_power_front;
    localparam int AW   = 6;
    localparam int IDLE = 4;
    localparam int REC  = (500 * 1000 + 10000 - 1) / 10000;

    logic          clk = 1'b0;
    logic          rst;
    logic          pd_n;
    logic [1:0]    ce_n;
    logic          wide;
    logic [AW-1:0] addr;
    logic [1:0]    mode;
    logic          oe, abrt, clr, lane;
    logic [AW-1:0] iaddr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    flashctl_power_front #(
        .ADDR_W(AW), .IDLE_CYC(IDLE), .CLK_PERIOD_PS(10000), .RECOVERY_NS(500)
    ) u0 (
        .clk(clk), .rst(rst), .pd_n_i(pd_n), .ce_n_i(ce_n), .wide_i(wide),
        .addr_i(addr), .mode_o(mode), .out_en_o(oe), .wsm_abort_o(abrt),
        .reg_clr_o(clr), .int_addr_o(iaddr), .lane_o(lane)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pd_n = 1'b1; ce_n = 2'b11; wide = 1'b1; addr = '0;
        tick(); tick();
        // R12 reset state
        chk("R12 mode", {30'd0, mode}, 32'h2);
        chk("R12 oe", {31'd0, oe}, 32'd0);
        chk("R12 abort", {31'd0, abrt}, 32'd0);
        chk("R12 clr", {31'd0, clr}, 32'd0);
        rst = 1'b0;

        // R2 R3 R4 deep power-down entry
        pd_n = 1'b0;
        tick();
        chk("R2 mode", {30'd0, mode}, 32'h3);
        chk("R3 abort first", {31'd0, abrt}, 32'd1);
        chk("R4 clr", {31'd0, clr}, 32'd1);
        chk("R9 oe deep", {31'd0, oe}, 32'd0);
        tick();
        chk("R3 abort second", {31'd0, abrt}, 32'd0);
        chk("R4 clr held", {31'd0, clr}, 32'd1);

        // R5 R7 R9 recovery and idle entry
        pd_n = 1'b1; ce_n = 2'b00;
        for (int n = 1; n <= REC + IDLE + 3; n++) begin
            tick();
            chk("R7 mode", {30'd0, mode}, (n >= IDLE + 1) ? 32'h1 : 32'h0);
            chk("R5 oe", {31'd0, oe}, (n >= REC) ? 32'd1 : 32'd0);
            chk("R4 clr off", {31'd0, clr}, 32'd0);
        end

        // R8 exit on address change, then re-entry
        addr = 6'd1;
        tick();
        chk("R8 mode", {30'd0, mode}, 32'h0);
        chk("R9 oe active", {31'd0, oe}, 32'd1);
        for (int k = 1; k <= IDLE + 3; k++) begin
            tick();
            chk("R7 reentry", {30'd0, mode}, (k >= IDLE + 1) ? 32'h1 : 32'h0);
            chk("R9 oe save", {31'd0, oe}, 32'd1);
        end

        // R1 R6 standby over saving
        ce_n = 2'b01;
        tick();
        chk("R6 R1 stby ce0", {30'd0, mode}, 32'h2);
        chk("R9 oe stby", {31'd0, oe}, 32'd0);
        ce_n = 2'b10;
        tick();
        chk("R6 stby ce1", {30'd0, mode}, 32'h2);
        ce_n = 2'b00;
        tick();
        chk("R7 restart active", {30'd0, mode}, 32'h0);
        chk("R9 oe back", {31'd0, oe}, 32'd1);

        // R1 deep over standby
        pd_n = 1'b0; ce_n = 2'b11;
        tick();
        chk("R1 deep prio", {30'd0, mode}, 32'h3);
        chk("R3 abort again", {31'd0, abrt}, 32'd1);
        ce_n = 2'b00;
        tick();
        chk("R1 deep held", {30'd0, mode}, 32'h3);
        chk("R3 abort drop", {31'd0, abrt}, 32'd0);
        pd_n = 1'b1;
        tick();
        chk("R1 leave deep", {30'd0, mode}, 32'h0);
        chk("R5 oe blocked", {31'd0, oe}, 32'd0);

        // R10 R11 address map sweep
        for (int w = 0; w < 2; w++) begin
            for (int a = 0; a < (1 << AW); a++) begin
                wide = w[0];
                addr = a[AW-1:0];
                #1;
                if (w == 1) begin
                    chk("R10 addr", {26'd0, iaddr}, 32'(a >> 1));
                    chk("R10 lane", {31'd0, lane}, 32'd0);
                end else begin
                    chk("R11 addr", {26'd0, iaddr}, 32'(a));
                    chk("R11 lane", {31'd0, lane}, 32'(a & 1));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule